// File: doc/BRIEF.md
# Cache Maintenance Command Unit

This unit carries out maintenance commands against a small set-associative tag store. Each line holds a tag, a valid bit and a lock bit. A requester hands over one command per cycle through a valid/ready handshake. A command is an opcode plus a physical address that an external translation stage has already produced, along with that stage's status flags. The unit looks up the tag store and applies the command to the line state. It then reports the outcome one cycle later as a set of single-cycle pulses: a completion pulse, one of two translation exceptions, or a prefetch request carrying a line-aligned address.

Three commands are supported. Line invalidate clears the valid bit of a matching line unless that line is locked. Touch and touch-for-store are prefetch hints that behave identically. A fourth opcode value is accepted and only completes. A separate preload port writes tag, valid and lock for one set and way directly. This port is used to set up locked or resident lines. While it writes, requests are held off.

The unit only acts on requests presented at its own port. It has no path by which commands from other agents could reach the tag store, and it sends no command outward. The default geometry is 2 ways by 16 sets with 16-byte lines on a 32-bit address.

Top module: `cache_maint_unit`

## Requirements
- R1: `reqReady` is high in every cycle in which `tpWrEn` is low and low whenever `tpWrEn` is high. Every accepted request (`reqValid && reqReady` at a rising edge) yields exactly one `doneValid` pulse, one cycle wide, in the cycle after the edge. This includes requests that change nothing. No pulse follows a cycle without acceptance.
- R2: An invalidate (`reqOp` = 2'b00) whose address matches a valid, unlocked line clears that line's valid bit at the accepting edge. A request accepted in the very next cycle already sees the line as absent.
- R3: An invalidate that matches no valid line, or that matches a locked line, changes no line state and raises neither exception.
- R4: The page attribute input `reqAttr` (write-through, caching-inhibited, guarded) has no effect on any outcome.
- R5: For protection, an invalidate is judged by the store-permission flag `reqProtStore` alone, and its `reqProtLoad` flag is ignored. Touches are judged by `reqProtLoad` alone, and their `reqProtStore` flag is ignored.
- R6: Touch (`reqOp` = 2'b01) and touch-for-store (`reqOp` = 2'b10) give identical results for identical inputs.
- R7: A touch that matches no valid line pulses `pfValid` for one cycle after acceptance, with `pfAddr` equal to the request address with its low 4 bits cleared. A touch that matches changes nothing and raises no pulse other than `doneValid`.
- R8: When `reqXlateMiss` and `reqRelocEn` are both high on an accepted request with opcode 00, 01 or 10, `excMiss` pulses after acceptance and no line state changes or prefetch follow. When `reqRelocEn` is low, `reqXlateMiss` is ignored.
- R9: A required protection flag (per R5) on an accepted command raises `excProt` with no state change or prefetch. A translation miss under R8 takes priority, so `excMiss`, `excProt` and `pfValid` are never high together.
- R10: Opcode 2'b11 only completes: no state change, exception or prefetch.
- R11: The set index is address bits [7:4] and the tag is bits [31:8]. A preload write (`tpWrEn`) stores `tpTag`, `tpValid` and `tpLock` into set `tpSet`, way `tpWay`, and the entry is visible to the next request. When several ways match, the lowest-numbered way is used.
- R12: Reset leaves every line invalid and unlocked and every output pulse low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken this cycle |
| reqOp | input | 2 | 00 invalidate, 01 touch, 10 touch-for-store, 11 no-op |
| reqAddr | input | 32 | Physical address of the command |
| reqAttr | input | 3 | Page attributes, no effect |
| reqXlateMiss | input | 1 | Translation found no mapping |
| reqRelocEn | input | 1 | Data relocation enabled |
| reqProtLoad | input | 1 | Load permission violated |
| reqProtStore | input | 1 | Store permission violated |
| tpWrEn | input | 1 | Preload write strobe |
| tpSet | input | 4 | Preload set index |
| tpWay | input | 1 | Preload way |
| tpTag | input | 24 | Preload tag |
| tpValid | input | 1 | Preload valid bit |
| tpLock | input | 1 | Preload lock bit |
| doneValid | output | 1 | Completion pulse |
| excMiss | output | 1 | Translation-miss exception pulse |
| excProt | output | 1 | Protection exception pulse |
| pfValid | output | 1 | Prefetch request pulse |
| pfAddr | output | 32 | Line-aligned prefetch address |

## Verification
`reqReady` is combinational and is checked in the same cycle as the inputs it depends on. `doneValid`, `excMiss`, `excProt`, `pfValid` and `pfAddr` come from one register stage and are due in the cycle after the accepting edge. Line-state changes take effect at that same edge, so a request issued in the very next cycle observes them. The bench drives inputs at the falling edge and forms its expectation from a behavioural line-state model. It waits through one rising edge and compares every output at the next falling edge. Hidden state such as a cleared valid bit or an untouched locked line is read back by issuing a touch and watching for a prefetch pulse.

// File: rtl/cmu_pkg.sv
`timescale 1ns/1ps
package cmu_pkg;

  typedef enum logic [1:0] {
    OP_INVAL    = 2'b00,
    OP_TOUCH    = 2'b01,
    OP_TOUCH_ST = 2'b10,
    OP_NONE     = 2'b11
  } cmuOp_e;

  // strobes from control to datapath / result stage
  typedef struct packed {
    logic invalidate;
    logic prefetch;
    logic excMiss;
    logic excProt;
    logic done;
  } cmuStrobe_t;

endpackage

// File: rtl/cmu_datapath.sv
`timescale 1ns/1ps
module cmu_datapath
  import cmu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WAYS       = 2,
  parameter int SETS       = 16,
  parameter int LINE_BYTES = 16,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reqAddr,
  input  cmuStrobe_t        strobe,
  input  logic              tpWrEn,
  input  logic [IDX_W-1:0]  tpSet,
  input  logic [WAY_W-1:0]  tpWay,
  input  logic [TAG_W-1:0]  tpTag,
  input  logic              tpValid,
  input  logic              tpLock,
  output logic              lookupHit,
  output logic              lookupLocked,
  output logic [ADDR_W-1:0] pfAddr
);

  logic [WAYS-1:0]  validQ [SETS];
  logic [WAYS-1:0]  lockQ  [SETS];
  logic [TAG_W-1:0] tagQ   [SETS][WAYS];

  logic [IDX_W-1:0] reqIdx;
  logic [TAG_W-1:0] reqTag;
  logic [OFF_W-1:0] unusedOffset;
  logic [WAYS-1:0]  wayHit;
  logic [WAY_W-1:0] hitWay;
  logic [ADDR_W-1:0] pfAddrQ;

  assign reqIdx       = reqAddr[OFF_W +: IDX_W];
  assign reqTag       = reqAddr[ADDR_W-1 -: TAG_W];
  assign unusedOffset = reqAddr[OFF_W-1:0];

  // per-way tag compare
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign wayHit[w] = validQ[reqIdx][w] && (tagQ[reqIdx][w] == reqTag);
  end

  // lowest matching way wins
  always_comb begin
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (wayHit[w]) hitWay = WAY_W'(w);
    end
  end

  assign lookupHit    = |wayHit;
  assign lookupLocked = lockQ[reqIdx][hitWay];

  // line state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        lockQ[s]  <= '0;
        for (int w = 0; w < WAYS; w++) tagQ[s][w] <= '0;
      end
    end else if (tpWrEn) begin
      validQ[tpSet][tpWay] <= tpValid;
      lockQ[tpSet][tpWay]  <= tpLock;
      tagQ[tpSet][tpWay]   <= tpTag;
    end else if (strobe.invalidate) begin
      validQ[reqIdx][hitWay] <= 1'b0;
    end
  end

  // prefetch address capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pfAddrQ <= '0;
    end else if (strobe.prefetch) begin
      pfAddrQ <= {reqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end
  end

  assign pfAddr = pfAddrQ;

endmodule

// File: rtl/cmu_ctrl.sv
`timescale 1ns/1ps
module cmu_ctrl
  import cmu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       reqXlateMiss,
  input  logic       reqRelocEn,
  input  logic       reqProtLoad,
  input  logic       reqProtStore,
  input  logic       tpWrEn,
  input  logic       lookupHit,
  input  logic       lookupLocked,
  output logic       reqReady,
  output cmuStrobe_t strobe,
  output logic       doneValid,
  output logic       excMiss,
  output logic       excProt,
  output logic       pfValid
);

  cmuOp_e op;
  logic   accept;
  logic   isInval;
  logic   isTouch;
  logic   protFault;

  assign reqReady  = !tpWrEn;
  assign accept    = reqValid && reqReady;
  assign op        = cmuOp_e'(reqOp);
  assign isInval   = (op == OP_INVAL);
  assign isTouch   = (op == OP_TOUCH) || (op == OP_TOUCH_ST);
  // invalidate checks like a store, touches like a load
  assign protFault = (isInval && reqProtStore) || (isTouch && reqProtLoad);

  always_comb begin
    strobe = '0;
    if (accept) begin
      strobe.done = 1'b1;
      if (isInval || isTouch) begin
        if (reqXlateMiss && reqRelocEn) begin
          strobe.excMiss = 1'b1;
        end else if (protFault) begin
          strobe.excProt = 1'b1;
        end else if (isInval) begin
          strobe.invalidate = lookupHit && !lookupLocked;
        end else begin
          strobe.prefetch = !lookupHit;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      doneValid <= 1'b0;
      excMiss   <= 1'b0;
      excProt   <= 1'b0;
      pfValid   <= 1'b0;
    end else begin
      doneValid <= strobe.done;
      excMiss   <= strobe.excMiss;
      excProt   <= strobe.excProt;
      pfValid   <= strobe.prefetch;
    end
  end

endmodule

// File: rtl/cache_maint_unit.sv
`timescale 1ns/1ps
module cache_maint_unit
  import cmu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WAYS       = 2,
  parameter int SETS       = 16,
  parameter int LINE_BYTES = 16,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqAttr,
  input  logic              reqXlateMiss,
  input  logic              reqRelocEn,
  input  logic              reqProtLoad,
  input  logic              reqProtStore,
  input  logic              tpWrEn,
  input  logic [IDX_W-1:0]  tpSet,
  input  logic [WAY_W-1:0]  tpWay,
  input  logic [TAG_W-1:0]  tpTag,
  input  logic              tpValid,
  input  logic              tpLock,
  output logic              doneValid,
  output logic              excMiss,
  output logic              excProt,
  output logic              pfValid,
  output logic [ADDR_W-1:0] pfAddr
);

  cmuStrobe_t strobe;
  logic       lookupHit;
  logic       lookupLocked;
  logic       unusedAttr;

  // page attributes do not steer any command
  assign unusedAttr = ^reqAttr;

  cmu_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .reqValid     (reqValid),
    .reqOp        (reqOp),
    .reqXlateMiss (reqXlateMiss),
    .reqRelocEn   (reqRelocEn),
    .reqProtLoad  (reqProtLoad),
    .reqProtStore (reqProtStore),
    .tpWrEn       (tpWrEn),
    .lookupHit    (lookupHit),
    .lookupLocked (lookupLocked),
    .reqReady     (reqReady),
    .strobe       (strobe),
    .doneValid    (doneValid),
    .excMiss      (excMiss),
    .excProt      (excProt),
    .pfValid      (pfValid)
  );

  cmu_datapath #(
    .ADDR_W     (ADDR_W),
    .WAYS       (WAYS),
    .SETS       (SETS),
    .LINE_BYTES (LINE_BYTES)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .reqAddr      (reqAddr),
    .strobe       (strobe),
    .tpWrEn       (tpWrEn),
    .tpSet        (tpSet),
    .tpWay        (tpWay),
    .tpTag        (tpTag),
    .tpValid      (tpValid),
    .tpLock       (tpLock),
    .lookupHit    (lookupHit),
    .lookupLocked (lookupLocked),
    .pfAddr       (pfAddr)
  );

endmodule

// File: rtl/cmu_checker.sv
`timescale 1ns/1ps
module cmu_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  localparam int OFF_W = $clog2(LINE_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic              reqReady,
  input logic [1:0]        reqOp,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqXlateMiss,
  input logic              reqRelocEn,
  input logic              reqProtLoad,
  input logic              reqProtStore,
  input logic              tpWrEn,
  input logic              doneValid,
  input logic              excMiss,
  input logic              excProt,
  input logic              pfValid,
  input logic [ADDR_W-1:0] pfAddr
);

  logic acc;
  logic xlMiss;
  assign acc    = reqValid && reqReady;
  assign xlMiss = reqXlateMiss && reqRelocEn;

  // R1
  ready_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tpWrEn |-> !reqReady);

  // R1
  accept_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> doneValid);

  // R1
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !doneValid);

  // R7
  pf_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pfValid |-> (pfAddr[OFF_W-1:0] == '0));

  // R7
  pf_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (reqOp == 2'b01 || reqOp == 2'b10)) |=>
      (!pfValid || pfAddr == (($past(reqAddr) >> OFF_W) << OFF_W)));

  // R8
  miss_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && xlMiss && reqOp != 2'b11) |=> (excMiss && !excProt && !pfValid));

  // R5
  inval_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !xlMiss && reqOp == 2'b00) |=> (excProt == $past(reqProtStore)));

  // R9
  single_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({excMiss, excProt, pfValid}));

  // R10
  noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && reqOp == 2'b11) |=> (!excMiss && !excProt && !pfValid));

  // R5
  touch_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !xlMiss && reqOp != 2'b00 && reqOp != 2'b11) |=> (excProt == $past(reqProtLoad)));

endmodule

bind cache_maint_unit cmu_checker #(
  .ADDR_W     (ADDR_W),
  .LINE_BYTES (LINE_BYTES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .reqOp        (reqOp),
  .reqAddr      (reqAddr),
  .reqXlateMiss (reqXlateMiss),
  .reqRelocEn   (reqRelocEn),
  .reqProtLoad  (reqProtLoad),
  .reqProtStore (reqProtStore),
  .tpWrEn       (tpWrEn),
  .doneValid    (doneValid),
  .excMiss      (excMiss),
  .excProt      (excProt),
  .pfValid      (pfValid),
  .pfAddr       (pfAddr)
);

// File: tb/cache_maint_unit_tb.sv
`timescale 1ns/1ps
module cache_maint_unit_tb;

  localparam int SETS = 16;
  localparam int WAYS = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqOp = 2'b00;
  logic [31:0] reqAddr = '0;
  logic [2:0]  reqAttr = '0;
  logic        reqXlateMiss = 1'b0;
  logic        reqRelocEn = 1'b0;
  logic        reqProtLoad = 1'b0;
  logic        reqProtStore = 1'b0;
  logic        tpWrEn = 1'b0;
  logic [3:0]  tpSet = '0;
  logic [0:0]  tpWay = '0;
  logic [23:0] tpTag = '0;
  logic        tpValid = 1'b0;
  logic        tpLock = 1'b0;
  logic        doneValid, excMiss, excProt, pfValid;
  logic [31:0] pfAddr;

  int    nChecks = 0;
  int    nFail = 0;
  bit    finished = 1'b0;
  string curReq = "R12";

  // behavioural line-state model
  bit          mValid [SETS][WAYS];
  bit          mLock  [SETS][WAYS];
  logic [23:0] mTag   [SETS][WAYS];

  always #5 clk = ~clk;

  cache_maint_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqAttr(reqAttr), .reqXlateMiss(reqXlateMiss), .reqRelocEn(reqRelocEn),
    .reqProtLoad(reqProtLoad), .reqProtStore(reqProtStore),
    .tpWrEn(tpWrEn), .tpSet(tpSet), .tpWay(tpWay), .tpTag(tpTag),
    .tpValid(tpValid), .tpLock(tpLock),
    .doneValid(doneValid), .excMiss(excMiss), .excProt(excProt),
    .pfValid(pfValid), .pfAddr(pfAddr)
  );

  function automatic logic [31:0] mkAddr(logic [23:0] t, logic [3:0] s, logic [3:0] o);
    return {t, s, o};
  endfunction

  task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %h expected %h", curReq, what, got, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    end
  endtask

  // one clock of stimulus: inputs already driven at a falling edge
  task automatic step();
    bit eDone, eMiss, eProt, ePf, eInv, acc, isInv, isTouch;
    logic [31:0] ePfAddr;
    int s, hw;
    logic [23:0] t;
    #1;
    chk("reqReady", 32'(reqReady), 32'(!tpWrEn));
    acc = reqValid && !tpWrEn;
    s = int'(reqAddr[7:4]);
    t = reqAddr[31:8];
    hw = -1;
    for (int w = 0; w < WAYS; w++)
      if (hw < 0 && mValid[s][w] && mTag[s][w] == t) hw = w;
    eDone = acc; eMiss = 0; eProt = 0; ePf = 0; eInv = 0;
    ePfAddr = {reqAddr[31:4], 4'h0};
    isInv   = (reqOp == 2'b00);
    isTouch = (reqOp == 2'b01) || (reqOp == 2'b10);
    if (acc && (isInv || isTouch)) begin
      if (reqXlateMiss && reqRelocEn) eMiss = 1;
      else if ((isInv && reqProtStore) || (isTouch && reqProtLoad)) eProt = 1;
      else if (isInv) eInv = (hw >= 0) && !mLock[s][hw];
      else ePf = (hw < 0);
    end
    @(posedge clk);
    if (tpWrEn) begin
      mValid[tpSet][tpWay] = tpValid;
      mLock[tpSet][tpWay]  = tpLock;
      mTag[tpSet][tpWay]   = tpTag;
    end else if (eInv) begin
      mValid[s][hw] = 0;
    end
    @(negedge clk);
    chk("doneValid", 32'(doneValid), 32'(eDone));
    chk("excMiss", 32'(excMiss), 32'(eMiss));
    chk("excProt", 32'(excProt), 32'(eProt));
    chk("pfValid", 32'(pfValid), 32'(ePf));
    if (ePf) chk("pfAddr", pfAddr, ePfAddr);
  endtask

  task automatic clearIn();
    reqValid = 0; reqOp = 0; reqAddr = 0; reqAttr = 0;
    reqXlateMiss = 0; reqRelocEn = 0; reqProtLoad = 0; reqProtStore = 0;
    tpWrEn = 0; tpSet = 0; tpWay = 0; tpTag = 0; tpValid = 0; tpLock = 0;
  endtask

  task automatic issue(logic [1:0] op, logic [31:0] addr,
                       bit miss = 0, bit reloc = 0, bit pl = 0, bit ps = 0,
                       logic [2:0] attr = 3'b000);
    reqValid = 1; reqOp = op; reqAddr = addr; reqAttr = attr;
    reqXlateMiss = miss; reqRelocEn = reloc; reqProtLoad = pl; reqProtStore = ps;
    step();
    clearIn();
  endtask

  task automatic preload(int s, int w, logic [23:0] t, bit v, bit l, bit withReq = 0);
    tpWrEn = 1; tpSet = 4'(s); tpWay = 1'(w); tpTag = t; tpValid = v; tpLock = l;
    if (withReq) begin
      reqValid = 1; reqOp = 2'b01; reqAddr = mkAddr(24'h777777, 4'(s), 4'h0);
    end
    step();
    clearIn();
  endtask

  task automatic idle();
    step();
  endtask

  localparam logic [23:0] TA = 24'h00A001;
  localparam logic [23:0] TB = 24'h00B002;
  localparam logic [23:0] TC = 24'h00C003;

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        mValid[s][w] = 0; mLock[s][w] = 0; mTag[s][w] = '0;
      end
    clearIn();
    repeat (3) @(negedge clk);
    // R12: outputs quiet during reset
    curReq = "R12";
    chk("doneValid@reset", 32'(doneValid), 0);
    chk("pfValid@reset", 32'(pfValid), 0);
    chk("excMiss@reset", 32'(excMiss), 0);
    chk("excProt@reset", 32'(excProt), 0);
    rst_n = 1;
    idle();
    // R12: every line starts invalid, so a touch prefetches
    issue(2'b01, mkAddr(24'h000000, 4'h0, 4'h0));
    issue(2'b01, mkAddr(TA, 4'h3, 4'h7));

    // R11: preload set 3 way 0 = A unlocked, way 1 = B locked
    curReq = "R11";
    preload(3, 0, TA, 1, 0);
    preload(3, 1, TB, 1, 1);
    issue(2'b01, mkAddr(TA, 4'h5, 4'h0));   // same tag other set: miss
    // R1: preload holds off a request
    curReq = "R1";
    preload(9, 1, TC, 1, 0, 1);
    idle();
    issue(2'b11, mkAddr(TC, 4'h9, 4'h0));

    // R7 / R6: hits do nothing, misses prefetch aligned line
    curReq = "R7";
    issue(2'b01, mkAddr(TA, 4'h3, 4'h4));
    issue(2'b01, mkAddr(TC, 4'h3, 4'hC));
    curReq = "R6";
    issue(2'b10, mkAddr(TB, 4'h3, 4'h0));
    issue(2'b10, mkAddr(TC, 4'h3, 4'hC));

    // R3: locked and missing lines survive invalidate
    curReq = "R3";
    issue(2'b00, mkAddr(TB, 4'h3, 4'h0));
    issue(2'b00, mkAddr(TC, 4'h3, 4'h0));
    issue(2'b01, mkAddr(TB, 4'h3, 4'h0));

    // R4 + R2: invalidate with all attributes set, then back-to-back touch
    curReq = "R4";
    issue(2'b00, mkAddr(TA, 4'h3, 4'h8), 0, 0, 0, 0, 3'b111);
    curReq = "R2";
    issue(2'b01, mkAddr(TA, 4'h3, 4'h0));

    // R8: translation miss with relocation blocks the invalidate
    curReq = "R8";
    preload(3, 0, TA, 1, 0);
    issue(2'b00, mkAddr(TA, 4'h3, 4'h0), 1, 1);
    issue(2'b01, mkAddr(TA, 4'h3, 4'h0));
    issue(2'b01, mkAddr(TC, 4'h6, 4'h0), 1, 1);
    issue(2'b00, mkAddr(TA, 4'h3, 4'h0), 1, 0); // reloc off: proceeds
    issue(2'b01, mkAddr(TA, 4'h3, 4'h0));

    // R5: invalidate judged by store flag, touch by load flag
    curReq = "R5";
    preload(3, 0, TA, 1, 0);
    issue(2'b00, mkAddr(TA, 4'h3, 4'h0), 0, 1, 0, 1);
    issue(2'b01, mkAddr(TA, 4'h3, 4'h0));
    issue(2'b00, mkAddr(TA, 4'h3, 4'h0), 0, 1, 1, 0);
    issue(2'b01, mkAddr(TA, 4'h3, 4'h0));
    issue(2'b01, mkAddr(TC, 4'h3, 4'h0), 0, 1, 1, 0);
    issue(2'b10, mkAddr(TC, 4'h3, 4'h0), 0, 1, 0, 1);

    // R9: miss has priority over protection
    curReq = "R9";
    issue(2'b00, mkAddr(TB, 4'h3, 4'h0), 1, 1, 1, 1);
    issue(2'b10, mkAddr(TC, 4'h2, 4'h0), 1, 1, 1, 1);

    // R10: reserved opcode only completes
    curReq = "R10";
    issue(2'b11, mkAddr(TB, 4'h3, 4'h0), 1, 1, 1, 1);
    issue(2'b11, mkAddr(TB, 4'h3, 4'h0));
    issue(2'b01, mkAddr(TB, 4'h3, 4'h0));

    // R11: two ways with same tag, unlocked way 0 goes first
    curReq = "R11";
    preload(12, 0, TC, 1, 0);
    preload(12, 1, TC, 1, 0);
    issue(2'b00, mkAddr(TC, 4'hC, 4'h0));
    issue(2'b01, mkAddr(TC, 4'hC, 4'h0));
    issue(2'b00, mkAddr(TC, 4'hC, 4'h0));
    issue(2'b01, mkAddr(TC, 4'hC, 4'h0));

    curReq = "R1";
    idle();
    idle();
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nChecks++;
      $display("FAIL R1 watchdog: got hung expected completion");
      summary();
      $finish;
    end
  end

endmodule